// File: doc/BRIEF.md
# Edge Change-Detection Interrupt Unit

This block watches a bank of already-filtered digital input channels and raises a single active-high interrupt when a selected transition occurs. Each channel has two enable bits of its own: one lets a low-to-high transition count, the other lets a high-to-low transition count. A control register adds two global mode gates, one for rising transitions and one for falling transitions. It also holds the interrupt enables.

The first qualifying transition sets a sticky edge flag. A further qualifying transition that arrives while the edge flag is still set also sets a sticky overflow flag. Software reads a status byte. If the interrupt-asserted bit in that byte is clear, the interrupt is not for this unit. To acknowledge, software writes ones to a write-one-to-clear register. Which channel changed, and when, is not recorded.

All configuration goes through a byte-wide register port. Writes take effect on the clock edge that samples them. Reads are combinational from the address. The interface has no data stream, so it has no valid/ready handshake. Every port is a plain control or status pin.

Top module: `ecd_irq_unit`

## Requirements
- R1: After reset, every mask byte, the control byte and the status byte read 0x00 and `irq` is low.
- R2: The rising-enable mask byte k sits at address 0x18+k, and the falling-enable mask byte k sits at 0x20+k. Bit j of byte k belongs to channel 8k+j. The bytes read back what was written. Mask addresses and bits beyond the channel count read 0.
- R3: A low-to-high change on a channel counts when two bits are set: the channel's rising mask bit and control bit 3 (rising mode). It sets status bit 0 (edge flag) at the clock edge that first samples the new level.
- R4: A high-to-low change on a channel counts when two bits are set: the channel's falling mask bit and control bit 4 (falling mode). It sets status bit 0 in the same way.
- R5: A change on a channel whose mask bit is clear, or whose mode bit in control is clear, leaves both status flags unchanged.
- R6: A qualifying change that is sampled while the edge flag is already set also sets status bit 1 (overflow). The edge flag stays set.
- R7: Writing the clear register at 0x07 with bit 3 set clears the edge flag. Writing it with bit 2 set clears the overflow flag. Its other bits have no effect, and the register reads 0x00.
- R8: If a qualifying change and a clear of the edge flag fall in the same cycle, the edge flag ends set.
- R9: `irq` equals control bit 2 (master) AND the OR of two terms: the edge flag with control bit 0, and the overflow flag with control bit 1. Status bit 2 reports the same value, and status bits 7:3 read 0.
- R10: The control register at 0x15 stores bits 4:0 of a write. Its bits 7:5 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_in | input | NUM_CH | Filtered channel levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench attacks the acknowledge race, in which a transition and a clear write land in the same cycle. A design that let the clear win would drop that event, and the status byte would read 0x00 instead of 0x05. It also checks the second transition before an acknowledge. A unit without overflow tracking would report 0x05 where 0x07 is due. A unit that cleared the edge flag there would lose the pending edge. Masked channels and disabled modes are toggled, and the status must not move. A design that ignored the per-channel or mode gating would set a flag. Finally, each interrupt-enable bit is switched off on its own. This shows that `irq` and status bit 2 follow only the enabled flags, and that both stay low without the master bit.

// File: rtl/ecd_pkg.sv
package ecd_pkg;

  localparam int REG_AW = 6;

  // byte addresses decoded by software
  localparam logic [REG_AW-1:0] ADR_CLEAR   = 6'h07;
  localparam logic [REG_AW-1:0] ADR_STATUS  = 6'h14;
  localparam logic [REG_AW-1:0] ADR_CONTROL = 6'h15;
  localparam logic [REG_AW-1:0] ADR_RISE0   = 6'h18;
  localparam logic [REG_AW-1:0] ADR_FALL0   = 6'h20;

  // acknowledge bits in the clear register
  localparam int ACK_EDGE_BIT = 3;
  localparam int ACK_OVF_BIT  = 2;

  // control byte, bit 4 down to bit 0
  typedef struct packed {
    logic fall_mode;
    logic rise_mode;
    logic master;
    logic ovf_en;
    logic edge_en;
  } ctl_t;

endpackage

// File: rtl/ecd_sampler.sv
module ecd_sampler #(
  parameter int NUM_CH = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] din,
  output logic [NUM_CH-1:0] rise_evt,
  output logic [NUM_CH-1:0] fall_evt
);

  logic [NUM_CH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= din;
  end

  // a change is the current level against the level one clock earlier
  assign rise_evt = din & ~prev_q;
  assign fall_evt = ~din & prev_q;

endmodule

// File: rtl/ecd_cfg_regs.sv
module ecd_cfg_regs
  import ecd_pkg::*;
#(
  parameter int NUM_CH = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_we,
  input  logic [REG_AW-1:0]          reg_addr,
  input  logic [7:0]                 reg_wdata,
  output logic [((NUM_CH+7)/8)*8-1:0] rise_bytes,
  output logic [((NUM_CH+7)/8)*8-1:0] fall_bytes,
  output ctl_t                       ctl,
  output logic                       clr_edge,
  output logic                       clr_ovf
);

  localparam int NBYTES = (NUM_CH + 7) / 8;
  localparam int MW     = NBYTES * 8;
  // only bits that map to a real channel are stored
  localparam logic [MW-1:0] KEEP = MW'((65'h1 << NUM_CH) - 65'h1);

  logic [MW-1:0] rise_q, fall_q;
  ctl_t          ctl_q;

  for (genvar b = 0; b < NBYTES; b++) begin : g_mask_byte
    localparam logic [REG_AW-1:0] RADR = ADR_RISE0 + REG_AW'(b);
    localparam logic [REG_AW-1:0] FADR = ADR_FALL0 + REG_AW'(b);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rise_q[8*b +: 8] <= '0;
        fall_q[8*b +: 8] <= '0;
      end else if (reg_we) begin
        if (reg_addr == RADR) rise_q[8*b +: 8] <= reg_wdata & KEEP[8*b +: 8];
        if (reg_addr == FADR) fall_q[8*b +: 8] <= reg_wdata & KEEP[8*b +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  ctl_q <= '0;
    else if (reg_we && reg_addr == ADR_CONTROL)  ctl_q <= ctl_t'(reg_wdata[4:0]);
  end

  assign rise_bytes = rise_q;
  assign fall_bytes = fall_q;
  assign ctl        = ctl_q;
  assign clr_edge   = reg_we && (reg_addr == ADR_CLEAR) && reg_wdata[ACK_EDGE_BIT];
  assign clr_ovf    = reg_we && (reg_addr == ADR_CLEAR) && reg_wdata[ACK_OVF_BIT];

  AST_CTL_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADR_CONTROL) |=> (ctl == $past(reg_wdata[4:0]))); // R10

endmodule

// File: rtl/ecd_flags.sv
module ecd_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr_edge,
  input  logic clr_ovf,
  input  logic edge_en,
  input  logic ovf_en,
  input  logic master,
  output logic edge_flag,
  output logic ovf_flag,
  output logic irq
);

  logic edge_q, ovf_q;

  // a new event always beats an acknowledge of the same flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (hit)           edge_q <= 1'b1;
      else if (clr_edge) edge_q <= 1'b0;

      if (hit && edge_q) ovf_q <= 1'b1;
      else if (clr_ovf)  ovf_q <= 1'b0;
    end
  end

  assign edge_flag = edge_q;
  assign ovf_flag  = ovf_q;
  assign irq       = master & ((edge_q & edge_en) | (ovf_q & ovf_en));

  AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> edge_flag); // R3
  AST_OVERFLOW_ON_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && edge_flag) |=> ovf_flag); // R6
  AST_OVERFLOW_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(edge_flag)); // R6
  AST_ACK_CLEARS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_edge && !hit) |=> !edge_flag); // R7
  AST_RACE_KEEPS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_edge && hit) |=> edge_flag); // R8
  AST_IRQ_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> !irq); // R9

endmodule

// File: rtl/ecd_irq_unit.sv
module ecd_irq_unit
  import ecd_pkg::*;
#(
  parameter int NUM_CH = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chan_in,
  input  logic              reg_we,
  input  logic [5:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq
);

  // mask bytes must fit below the falling-mask base
  localparam int NBYTES = (NUM_CH + 7) / 8;
  localparam int MW     = NBYTES * 8;

  logic [NUM_CH-1:0] rise_evt, fall_evt;
  logic [MW-1:0]     rise_bytes, fall_bytes;
  ctl_t              ctl;
  logic              clr_edge, clr_ovf;
  logic              hit;
  logic              edge_flag, ovf_flag, irq_w;

  ecd_sampler #(.NUM_CH(NUM_CH)) u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (chan_in),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  ecd_cfg_regs #(.NUM_CH(NUM_CH)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .rise_bytes (rise_bytes),
    .fall_bytes (fall_bytes),
    .ctl        (ctl),
    .clr_edge   (clr_edge),
    .clr_ovf    (clr_ovf)
  );

  assign hit = |((rise_evt & rise_bytes[NUM_CH-1:0] & {NUM_CH{ctl.rise_mode}}) |
                 (fall_evt & fall_bytes[NUM_CH-1:0] & {NUM_CH{ctl.fall_mode}}));

  ecd_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit),
    .clr_edge  (clr_edge),
    .clr_ovf   (clr_ovf),
    .edge_en   (ctl.edge_en),
    .ovf_en    (ctl.ovf_en),
    .master    (ctl.master),
    .edge_flag (edge_flag),
    .ovf_flag  (ovf_flag),
    .irq       (irq_w)
  );

  assign irq = irq_w;

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == ADR_STATUS)  reg_rdata = {5'b0, irq_w, ovf_flag, edge_flag};
    if (reg_addr == ADR_CONTROL) reg_rdata = {3'b0, ctl};
    for (int b = 0; b < NBYTES; b++) begin
      if (reg_addr == ADR_RISE0 + REG_AW'(b)) reg_rdata = rise_bytes[8*b +: 8];
      if (reg_addr == ADR_FALL0 + REG_AW'(b)) reg_rdata = fall_bytes[8*b +: 8];
    end
  end

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_flag && !ovf_flag) |-> !irq); // R9

endmodule

// File: tb/test_ecd_irq_unit.sv
module test_ecd_irq_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 24;
  localparam int NBYTES     = (NUM_CH + 7) / 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NUM_CH-1:0] din = '0;
  logic              we = 1'b0;
  logic [5:0]        addr = '0;
  logic [7:0]        wdata = '0;
  logic [7:0]        rdata;
  logic              irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecd_irq_unit #(.NUM_CH(NUM_CH)) i_ecd_irq_unit (
    .clk(clk), .rst_n(rst_n), .chan_in(din), .reg_we(we),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq)
  );

  // behavioural reference
  logic [63:0]       m_rise, m_fall;
  logic [4:0]        m_ctl;
  bit                m_edge, m_ovf, m_hit;
  logic [NUM_CH-1:0] m_prev;

  function automatic bit m_irq();
    return m_ctl[2] && ((m_edge && m_ctl[0]) || (m_ovf && m_ctl[1]));
  endfunction

  function automatic logic [7:0] m_read(input logic [5:0] a);
    if (a == 6'h14) return {5'b0, m_irq(), m_ovf, m_edge};
    if (a == 6'h15) return {3'b0, m_ctl};
    for (int k = 0; k < NBYTES; k++) begin
      if (a == 6'h18 + 6'(k)) return m_rise[8*k +: 8];
      if (a == 6'h20 + 6'(k)) return m_fall[8*k +: 8];
    end
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rise = '0; m_fall = '0; m_ctl = '0;
      m_edge = 0; m_ovf = 0; m_prev = '0;
    end else begin
      m_hit = 0;
      for (int c = 0; c < NUM_CH; c++) begin
        if (din[c] && !m_prev[c] && m_rise[c] && m_ctl[3]) m_hit = 1;
        if (!din[c] && m_prev[c] && m_fall[c] && m_ctl[4]) m_hit = 1;
      end
      if (m_hit && m_edge) m_ovf = 1;
      else if (we && addr == 6'h07 && wdata[2]) m_ovf = 0;
      if (m_hit) m_edge = 1;
      else if (we && addr == 6'h07 && wdata[3]) m_edge = 0;
      if (we) begin
        if (addr == 6'h15) m_ctl = wdata[4:0];
        for (int k = 0; k < NBYTES; k++) begin
          if (addr == 6'h18 + 6'(k)) m_rise[8*k +: 8] = wdata;
          if (addr == 6'h20 + 6'(k)) m_fall[8*k +: 8] = wdata;
        end
      end
      m_prev = din;
    end
  end

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  // every clock: irq against the reference (R9)
  always @(negedge clk) begin
    if (rst_n && !done) check("R9 irq per cycle", {7'b0, irq}, {7'b0, m_irq()});
  end

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [5:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    check(req, rdata, exp);
    check({req, " model"}, rdata, m_read(a));
  endtask

  task automatic drive(input logic [NUM_CH-1:0] v);
    @(negedge clk); din = v;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rd("R1 status", 6'h14, 8'h00);
    rd("R1 control", 6'h15, 8'h00);
    for (int k = 0; k < NBYTES; k++) begin
      rd("R1 rise mask", 6'h18 + 6'(k), 8'h00);
      rd("R1 fall mask", 6'h20 + 6'(k), 8'h00);
    end
    check("R1 irq", {7'b0, irq}, 8'h00);

    // R2 mask layout and readback
    wr(6'h18, 8'h01);
    wr(6'h1A, 8'h80);
    rd("R2 rise byte0", 6'h18, 8'h01);
    rd("R2 rise byte1", 6'h19, 8'h00);
    rd("R2 rise byte2", 6'h1A, 8'h80);
    wr(6'h1B, 8'hFF);
    rd("R2 beyond channels", 6'h1B, 8'h00);
    wr(6'h22, 8'h3C);
    rd("R2 fall byte2", 6'h22, 8'h3C);
    wr(6'h22, 8'h00);

    // R10 control storage
    wr(6'h15, 8'hFD);
    rd("R10 control", 6'h15, 8'h1D);

    // R3 rising edge on masked channel 0
    drive(24'h000001);
    rd("R3 rise sets edge", 6'h14, 8'h05);
    check("R3 irq", {7'b0, irq}, 8'h01);
    wr(6'h07, 8'h0C);
    rd("R7 ack both", 6'h14, 8'h00);
    rd("R7 clear reads zero", 6'h07, 8'h00);

    // R5 unmasked channel, then mode bit off
    drive(24'h000003);
    rd("R5 unmasked channel", 6'h14, 8'h00);
    wr(6'h15, 8'h15);
    drive(24'h800003);
    rd("R5 rise mode off", 6'h14, 8'h00);
    wr(6'h15, 8'h1D);

    // R4 falling edge on channel 1
    wr(6'h20, 8'h02);
    drive(24'h800001);
    rd("R4 fall sets edge", 6'h14, 8'h05);

    // R6 second event before acknowledge
    drive(24'h800000);
    rd("R5 unmasked fall", 6'h14, 8'h05);
    drive(24'h800001);
    rd("R6 overflow", 6'h14, 8'h07);

    // R7 acknowledge bits individually
    wr(6'h07, 8'h04);
    rd("R7 ovf ack", 6'h14, 8'h05);
    wr(6'h07, 8'h73);
    rd("R7 other bits ignored", 6'h14, 8'h05);
    wr(6'h07, 8'h08);
    rd("R7 edge ack", 6'h14, 8'h00);

    // R9 overflow-only interrupt enable
    wr(6'h15, 8'h1E);
    drive(24'h800000);
    drive(24'h800001);
    rd("R9 edge without edge_en", 6'h14, 8'h01);
    drive(24'h800000);
    drive(24'h800001);
    rd("R9 overflow raises irq", 6'h14, 8'h07);
    wr(6'h07, 8'h0C);

    // R9 master off
    wr(6'h15, 8'h1B);
    drive(24'h800000);
    drive(24'h800001);
    rd("R9 master off", 6'h14, 8'h01);
    check("R9 irq master off", {7'b0, irq}, 8'h00);
    wr(6'h07, 8'h0C);

    // R8 event and acknowledge in the same cycle
    wr(6'h15, 8'h1D);
    drive(24'h800000);
    @(negedge clk); din = 24'h800001; we = 1'b1; addr = 6'h07; wdata = 8'h0C;
    @(negedge clk); we = 1'b0;
    rd("R8 race keeps edge", 6'h14, 8'h05);
    drive(24'h800000);
    @(negedge clk); din = 24'h800001; we = 1'b1; addr = 6'h07; wdata = 8'h0C;
    @(negedge clk); we = 1'b0;
    rd("R8 race with pending", 6'h14, 8'h07);
    wr(6'h07, 8'h0C);
    rd("R7 final ack", 6'h14, 8'h00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule